// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupt

This block is one bank of up to 32 general-purpose pins. It sits behind a small word-addressed register bus. Software uses it to choose each pin's direction, to drive output levels and to read the live pin levels. It can also latch selected transitions on the pins into a status register that raises one interrupt. The pad itself is modelled as three vectors: the sampled input, the output value and the output enable.

Output levels are never written directly. A pin is raised through a write-one-to-set register and lowered through a write-one-to-clear register, so several agents can drive different pins without a read-modify-write. Rising and falling detection are enabled separately for each pin. Detected edges collect in a sticky status register, and each bit stays set until software writes a one to it. A build-time polarity mask reverses the meaning of the direction bit for selected pins. A build-time pin count lets a partly populated bank drop its upper bits.

Top module: `pio_bank`

## Requirements
- R1: Bits at or above NPINS read as zero in every register, ignore writes, never set status, and never drive `pin_out` or `pin_oe`.
- R2: Reading word 0 returns the two-flop synchronised level of every implemented pin, whatever its direction.
- R3: Writing word 2 sets the output latch bits where the write data has a one and leaves the other bits alone. `pin_out` shows the latch one cycle later.
- R4: Writing word 3 clears the output latch bits where the write data has a one and leaves the other bits alone.
- R5: Word 1 is the read/write direction register. `pin_oe` equals that register XOR the INV_MASK parameter, so a 1 means output on normal pins and input on inverted pins. Reset loads INV_MASK, which makes every pin an input.
- R6: Word 4 enables rising detection and word 5 enables falling detection. A status bit is set one clock after the synchronised level shows an enabled transition.
- R7: Word 6 is the sticky edge status. Writing a one to a bit clears it. Writing a zero leaves it unchanged.
- R8: If an edge is detected on a bit in the same cycle as a clear write to that bit, the bit stays set.
- R9: `irq` is high exactly while any status bit is set. It changes on the same clock edge as the status.
- R10: Synchronous reset clears both edge enables, the status, the output latch, `irq` and the read data.
- R11: Reads of words 2, 3 and 7 return zero. Read data is registered and appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word index of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output latch to pads |
| pin_oe | output | 32 | Output enable to pads |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench times a clear write to land on the very clock edge at which a new edge is captured on the same bit. A design that gave the clear priority would lose that event and drop `irq`. It toggles pins above the implemented count with every enable set and checks that no status appears. It writes zero to status to show the bits are sticky, and then clears them one at a time. The bench runs with inverted pins, which exposes a design that decodes direction without the polarity mask or resets it to zero: such a design would drive those pins as outputs straight out of reset.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 32;
  localparam int AW     = 3;

  typedef enum logic [AW-1:0] {
    RG_LEVEL = 3'd0,
    RG_DIR   = 3'd1,
    RG_SET   = 3'd2,
    RG_CLR   = 3'd3,
    RG_RISE  = 3'd4,
    RG_FALL  = 3'd5,
    RG_STAT  = 3'd6,
    RG_NONE  = 3'd7
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] impl_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign hit[g] = (rise_en[g] &  level[g] & ~prev_q[g]) |
                    (fall_en[g] & ~level[g] &  prev_q[g]);
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int                NPINS    = 32,
  parameter logic [DATA_W-1:0] INV_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL    = impl_mask(NPINS);
  localparam logic [DATA_W-1:0] DIR_RST = INV_MASK & IMPL;

  reg_sel_e          sel;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] sync_lvl, lvl, hit;
  logic [DATA_W-1:0] dir_q, rise_q, fall_q, stat_q, stat_d, rd_d;

  assign sel   = reg_sel_e'(bus_addr);
  assign wmask = bus_wdata & IMPL;

  pio_sync #(.W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_lvl)
  );

  assign lvl = sync_lvl & IMPL;

  pio_edge #(.W(DATA_W)) u_edge (
    .clk(clk), .rst(rst), .level(lvl),
    .rise_en(rise_q), .fall_en(fall_q), .hit(hit)
  );

  always_comb begin
    stat_d = stat_q;
    if (bus_we && sel == RG_STAT) stat_d = stat_d & ~wmask;
    stat_d = (stat_d | hit) & IMPL;
  end

  always_comb begin
    unique case (sel)
      RG_LEVEL: rd_d = lvl;
      RG_DIR:   rd_d = dir_q;
      RG_RISE:  rd_d = rise_q;
      RG_FALL:  rd_d = fall_q;
      RG_STAT:  rd_d = stat_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= '0;
      dir_q     <= DIR_RST;
      pin_oe    <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      stat_q    <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        case (sel)
          RG_DIR: begin
            dir_q  <= wmask;
            pin_oe <= (wmask ^ INV_MASK) & IMPL;
          end
          RG_SET:  pin_out <= pin_out | wmask;
          RG_CLR:  pin_out <= pin_out & ~wmask;
          RG_RISE: rise_q  <= wmask;
          RG_FALL: fall_q  <= wmask;
          default: ;
        endcase
      end
      stat_q    <= stat_d;
      irq       <= |stat_d;
      bus_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int                NPINS    = 32,
  parameter logic [DATA_W-1:0] INV_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_oe,
  input logic              irq,
  input logic [DATA_W-1:0] stat
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NPINS);

  a_r3_set_raises: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RG_SET) |=>
      ((pin_out & $past(bus_wdata) & IMPL) == ($past(bus_wdata) & IMPL)));

  a_r4_clr_lowers: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RG_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

  a_r5_oe_polarity: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RG_DIR) |=>
      (pin_oe == (($past(bus_wdata) ^ INV_MASK) & IMPL)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == RG_STAT) |=> ((stat & $past(stat)) == $past(stat)));

  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (stat != '0));

  a_r1_unimpl_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pin_out | pin_oe | stat) & ~IMPL) == '0);
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS), .INV_MASK(INV_MASK)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .stat(stat_q)
);

// File: tb/tb_pio_bank.sv
module tb_pio_bank;
  localparam int          NP  = 24;
  localparam logic [31:0] INV = 32'h0000_00F0;
  localparam int          NT  = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pio_bank #(.NPINS(NP), .INV_MASK(INV)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // row: {req[3:0], op[1:0], addr[2:0], value[31:0]}; op 0 write, 1 read, 2 pin_out, 3 pin_oe
  localparam logic [40:0] TBL [NT] = '{
    {4'd5,  2'd0, 3'd1, 32'hFFFF_FFFF},
    {4'd1,  2'd1, 3'd1, 32'h00FF_FFFF},  // R1 upper direction bits dropped
    {4'd5,  2'd3, 3'd0, 32'h00FF_FF0F},  // R5 inverted pins become inputs
    {4'd5,  2'd0, 3'd1, 32'h0000_0000},
    {4'd5,  2'd3, 3'd0, 32'h0000_00F0},  // R5
    {4'd3,  2'd0, 3'd2, 32'h0000_0F0F},
    {4'd3,  2'd2, 3'd0, 32'h0000_0F0F},  // R3
    {4'd1,  2'd0, 3'd2, 32'hFF00_0010},
    {4'd1,  2'd2, 3'd0, 32'h0000_0F1F},  // R1 and R3
    {4'd4,  2'd0, 3'd3, 32'h0000_0103},
    {4'd4,  2'd2, 3'd0, 32'h0000_0E1C},  // R4
    {4'd11, 2'd1, 3'd2, 32'h0000_0000},  // R11
    {4'd11, 2'd1, 3'd3, 32'h0000_0000},  // R11
    {4'd11, 2'd1, 3'd7, 32'h0000_0000},  // R11
    {4'd6,  2'd0, 3'd4, 32'hFFFF_FFFF},
    {4'd6,  2'd1, 3'd4, 32'h00FF_FFFF},  // R6
    {4'd6,  2'd0, 3'd5, 32'h0000_FFFF},
    {4'd6,  2'd1, 3'd5, 32'h0000_FFFF},  // R6
    {4'd6,  2'd0, 3'd4, 32'h0000_0000},
    {4'd6,  2'd0, 3'd5, 32'h0000_0000}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check(10, {31'd0, irq}, 32'd0);
    check(10, pin_out, 32'd0);
    check(5, pin_oe, 32'd0);           // R5 all inputs after reset
    rd(3'd1, r); check(5, r, 32'h0000_00F0);
    rd(3'd6, r); check(10, r, 32'd0);
    rd(3'd4, r); check(10, r, 32'd0);
    rd(3'd5, r); check(10, r, 32'd0);

    for (int i = 0; i < NT; i++) begin
      logic [40:0] row;
      row = TBL[i];
      case (row[36:35])
        2'd0: wr(row[34:32], row[31:0]);
        2'd1: begin rd(row[34:32], r); check(int'(row[40:37]), r, row[31:0]); end
        2'd2: begin @(negedge clk); check(int'(row[40:37]), pin_out, row[31:0]); end
        default: begin @(negedge clk); check(int'(row[40:37]), pin_oe, row[31:0]); end
      endcase
    end

    // R2 level readback, independent of direction; R1 upper bits zero
    drive_pins(32'hA5A5_A5A5);
    rd(3'd0, r); check(2, r, 32'h00A5_A5A5);
    drive_pins(32'h0000_0000);
    rd(3'd0, r); check(2, r, 32'h0000_0000);

    // R6 rise on bit0, fall on bit1
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h2);
    drive_pins(32'h3);
    rd(3'd6, r); check(6, r, 32'h1);
    check(9, {31'd0, irq}, 32'd1);     // R9
    drive_pins(32'h0);
    rd(3'd6, r); check(6, r, 32'h3);

    // R7 zero write no effect, one clears
    wr(3'd6, 32'h0);
    rd(3'd6, r); check(7, r, 32'h3);
    wr(3'd6, 32'h2);
    rd(3'd6, r); check(7, r, 32'h1);
    check(9, {31'd0, irq}, 32'd1);

    // R8 clear lands on the capture edge of a new rise on bit0
    @(negedge clk);
    pin_in = 32'h1;
    repeat (2) @(negedge clk);
    bus_addr = 3'd6; bus_we = 1'b1; bus_wdata = 32'h1;
    @(negedge clk);
    bus_we = 1'b0;
    check(8, {31'd0, irq}, 32'd1);
    rd(3'd6, r); check(8, r, 32'h1);

    wr(3'd6, 32'h1);
    check(9, {31'd0, irq}, 32'd0);     // R9 drops with last bit
    rd(3'd6, r); check(7, r, 32'h0);

    // R1 pins above NPINS never raise status
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    drive_pins(32'hFF00_0001);
    drive_pins(32'h0000_0001);
    rd(3'd6, r); check(1, r, 32'h0);
    check(1, {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule